// File: doc/BRIEF.md
# Bit-Serial Successive Approximation Controller

This block is the digital sequencer of a 14-bit successive-approximation converter. It puts a trial code on an external capacitive DAC and reads back one comparator decision per clock. It settles the code one bit at a time, starting at the most significant bit. A single-hot token walks down a chain of flip-flops, and its position selects the bit being decided.

Holding the active-low reset starts a new conversion. The reset puts the token on the top stage and the trial code at midscale. After reset is released, each rising edge does three things: it stores the comparator level into the bit under test, raises the next lower bit for the next trial, and moves the token one stage down. At the edge that settles the least significant bit, the finished code is copied into a result register and a one-cycle done pulse is raised. The controller then stays quiet until the next reset.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While `rst_n` is low (asynchronous), `trial_code` is midscale (bit 13 set, bits 12..0 clear), `done` is 0 and `result` is 0.
- R2: `cmp_hi` = 1 means the held input is above the DAC output. A 1 sampled at an edge leaves the bit under test at 1. A 0 clears it to 0.
- R3: Bits are decided from bit 13 down to bit 0. The edge numbered k after reset release (k = 1..14) decides bit 14-k. When that bit is above bit 0, the same edge sets bit 13-k to 1 for the next trial.
- R4: After its deciding edge, a code bit keeps its value until the next reset.
- R5: `done` is 1 for exactly one cycle. That cycle follows the 14th edge after reset release.
- R6: `result` loads the completed code at the edge that raises `done`. It keeps that value until the next reset.
- R7: After the final decision, `trial_code`, `result` and `done` do not change, whatever `cmp_hi` does.
- R8: Asserting `rst_n` low in the middle of a conversion abandons it. The controller restarts from midscale.
- R9: `cmp_hi` counts only at rising clock edges. A level change between edges that is undone before the edge has no effect.
- R10: With an ideal comparator and a held input code v, the result is v-1 for v > 0 and 0 for v = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all decisions are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; starts a conversion at midscale |
| cmp_hi | input | 1 | Comparator level; 1 when the held input exceeds the DAC output |
| trial_code | output | 14 | Trial code driving the external DAC |
| result | output | 14 | Completed conversion code |
| done | output | 1 | One-cycle pulse marking a finished conversion |

## Verification
The assertions assume that `cmp_hi` is a clean level, meaning neither X nor changing at the sampling edge. They also assume that every reset pulse covers at least one rising edge. The bench drives the comparator level and the reset only at a fixed offset after each rising edge, and its short glitches always end several nanoseconds before the next edge. The level therefore stays settled across every sampling point. Stimulus covers an ideal comparator at the code extremes and around midscale, fixed decision patterns with and without mid-cycle glitches, toggling in the idle phase, and a reset that cuts a conversion short.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_LAST = 2'd1,
    SEQ_IDLE = 2'd2
  } seq_phase_e;

  // Phase of the sequencer from the token chain
  function automatic seq_phase_e phase_of(input logic any_tok, input logic lsb_tok);
    if (!any_tok)     return SEQ_IDLE;
    else if (lsb_tok) return SEQ_LAST;
    else              return SEQ_RUN;
  endfunction

  // Next value of one code bit given its own token, the token above and the decision
  function automatic logic code_bit_next(input logic cur, input logic own_tok,
                                         input logic upper_tok, input logic decision);
    if (own_tok)        return decision;
    else if (upper_tok) return 1'b1;
    else                return cur;
  endfunction

endpackage

// File: rtl/sar_token_chain.sv
module sar_token_chain #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] tok_o
);
  localparam int TOP = W - 1;

  generate
    for (genvar s = 0; s < W; s++) begin : g_stage
      if (s == TOP) begin : g_head
        // Head stage: preset in reset, empties on the first edge
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) tok_o[s] <= 1'b1;
          else        tok_o[s] <= 1'b0;
        end
      end else begin : g_body
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) tok_o[s] <= 1'b0;
          else        tok_o[s] <= tok_o[s+1];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tok_i,
  input  logic         cmp_i,
  output logic [W-1:0] code_o
);
  import sar_pkg::*;
  localparam int TOP = W - 1;

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic upper_tok;
      if (b == TOP) begin : g_top
        assign upper_tok = 1'b0;
      end else begin : g_low
        assign upper_tok = tok_i[b+1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_o[b] <= (b == TOP);
        else        code_o[b] <= code_bit_next(code_o[b], tok_i[b], upper_tok, cmp_i);
      end
    end
  endgenerate
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture_i,
  input  logic [W-1:0] final_i,
  output logic [W-1:0] result_o,
  output logic         done_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= capture_i;
      if (capture_i) result_o <= final_i;
    end
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_hi,
  output logic [W-1:0] trial_code,
  output logic [W-1:0] result,
  output logic         done
);
  import sar_pkg::*;

  // Named internal events, visible to the bound checker
  logic [W-1:0] tok_stage;
  logic         lsb_step;
  logic [W-1:0] final_code;
  seq_phase_e   seq_phase;

  sar_token_chain #(.W(W)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .tok_o (tok_stage)
  );

  sar_code_reg #(.W(W)) u_code (
    .clk    (clk),
    .rst_n  (rst_n),
    .tok_i  (tok_stage),
    .cmp_i  (cmp_hi),
    .code_o (trial_code)
  );

  assign lsb_step   = tok_stage[0];
  assign final_code = {trial_code[W-1:1], cmp_hi};
  assign seq_phase  = phase_of(|tok_stage, lsb_step);

  sar_result_reg #(.W(W)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (lsb_step),
    .final_i   (final_code),
    .result_o  (result),
    .done_o    (done)
  );
endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk #(
  parameter int W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_hi,
  input logic [W-1:0]      trial_code,
  input logic [W-1:0]      result,
  input logic              done,
  input logic [W-1:0]      tok_stage,
  input sar_pkg::seq_phase_e seq_phase
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_mid_chk: assert (trial_code == MID && !done && result == '0)
        else $error("reset state wrong");
    end
  end

  // R3
  token_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_stage != '0) |=> (tok_stage == ($past(tok_stage) >> 1)));

  // R3
  token_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tok_stage));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_after_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_stage[0] |=> done);

  // R6
  result_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result == trial_code));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_phase == sar_pkg::SEQ_IDLE) |=> ($stable(trial_code) && $stable(result)));

  generate
    for (genvar b = 0; b < W; b++) begin : g_bitchk
      // R2
      decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_stage[b] |=> (trial_code[b] == $past(cmp_hi)));
      // R4
      frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tok_stage >> b) == '0) |=> $stable(trial_code[b]));
    end
  endgenerate
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmp_hi     (cmp_hi),
  .trial_code (trial_code),
  .result     (result),
  .done       (done),
  .tok_stage  (tok_stage),
  .seq_phase  (seq_phase)
);

// File: tb/tb_sar_seq_ctrl.sv
module tb_sar_seq_ctrl;
  localparam int W = 14;
  localparam logic [W-1:0] MID = 14'h2000;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic mode_pat = 1'b0;
  logic pat_val = 1'b0;
  logic [W-1:0] vin = '0;
  logic cmp_hi;
  logic [W-1:0] trial_code, result;
  logic done;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit started = 0;

  always #10 clk = ~clk;

  assign cmp_hi = mode_pat ? pat_val : (vin > trial_code);

  sar_seq_ctrl #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi),
    .trial_code(trial_code), .result(result), .done(done)
  );

  // Behavioural reference: bit index walks down, -1 means idle
  int m_code = int'(MID), m_res = 0, m_bit = W - 1;
  bit m_done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = int'(MID); m_res = 0; m_bit = W - 1; m_done = 0;
    end else begin
      m_done = 0;
      if (m_bit >= 0) begin
        if (cmp_hi) m_code = m_code | (1 << m_bit);
        else        m_code = m_code & ~(1 << m_bit);
        if (m_bit > 0) m_code = m_code | (1 << (m_bit - 1));
        if (m_bit == 0) begin m_done = 1; m_res = m_code; end
        m_bit = m_bit - 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (started) begin
      string rq;
      if (!rst_n)       rq = "R1";
      else if (m_done)  rq = "R5/R6";
      else if (m_bit < 0) rq = "R7";
      else              rq = "R2/R3/R4";
      check({rq, " trial_code"}, int'(trial_code), m_code);
      check({rq, " done"}, int'(done), int'(m_done));
      check({rq, " result"}, int'(result), m_res);
    end
  end

  task automatic start_conv();
    @(posedge clk); #5 rst_n = 1'b0;
    @(posedge clk); #5 rst_n = 1'b1;
  endtask

  task automatic run_ideal(input logic [W-1:0] v);
    mode_pat = 1'b0; vin = v;
    start_conv();
    repeat (W + 3) @(posedge clk);
    #5;
    // R10 closed-form expectation
    check("R10 result", int'(result), (v == 0) ? 0 : int'(v) - 1);
  endtask

  task automatic run_pat(input logic [W-1:0] p, input bit glitch);
    mode_pat = 1'b1;
    @(posedge clk); #5 rst_n = 1'b0;
    @(posedge clk); #5 rst_n = 1'b1; pat_val = p[W-1];
    for (int k = 1; k <= W; k++) begin
      if (glitch) begin
        #7 pat_val = ~pat_val;   // R9 short mid-cycle glitch
        #4 pat_val = ~pat_val;
      end
      @(posedge clk); #5;
      if (k < W) pat_val = p[W-1-k];
    end
    // R7 toggle comparator during idle
    for (int j = 0; j < 6; j++) begin
      pat_val = ~pat_val;
      @(posedge clk); #5;
    end
    check("R6 pattern result", int'(result), int'(p));
    check("R7 idle code", int'(trial_code), int'(p));
  endtask

  initial begin
    #1 rst_n = 1'b0;
    started = 1;
    #2;
    check("R1 reset code", int'(trial_code), int'(MID));
    check("R1 reset done", int'(done), 0);
    check("R1 reset result", int'(result), 0);
    run_ideal(14'd0);
    run_ideal(14'h3FFF);
    run_ideal(14'h2000);
    run_ideal(14'h1FFF);
    run_ideal(14'h2001);
    run_ideal(14'd1);
    run_ideal(14'd2);
    run_ideal(14'd12345);
    run_pat(14'h2AAA, 1'b0);
    run_pat(14'h1555, 1'b1);
    run_pat(14'h3FFF, 1'b1);
    run_pat(14'h0000, 1'b0);
    // R8 abort mid conversion
    mode_pat = 1'b0; vin = 14'd4321;
    start_conv();
    repeat (5) @(posedge clk);
    #5 rst_n = 1'b0;
    #2 check("R8 abort midscale", int'(trial_code), int'(MID));
    @(posedge clk); #5 rst_n = 1'b1;
    repeat (W + 3) @(posedge clk);
    #5 check("R8 restart result", int'(result), 4320);
    run_ideal(14'd777);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule